// File: doc/BRIEF.md
# I2C Transmit Status Flags with Transfer-Controller Request

This block keeps the status flags that a byte-oriented I2C transmitter raises each time it finishes sending a byte. It holds three flags: data-register-empty, interrupt and transfer-request. The byte-done strobe from the bit-level shifter sets them. How many of them it sets depends on whether acknowledge checking is on and on the acknowledge bit the receiver returned.

While bytes remain in a preloaded down-counter, the transfer-request flag raises a request to an external DMA-style transfer controller. Each service strobe from that controller writes the next byte and silently clears all three flags, so a bulk transfer runs without CPU interrupts. A NACK seen under acknowledge checking does not produce a request. Neither does the byte that follows the last counted DMA write. In both cases the interrupt flag stays set and reaches the CPU line. The CPU can also clear flags by writing zeros.

The shifter, start/stop generation and the transfer engine are outside this block and appear only as single-cycle strobes. No data path crosses the boundary, so every pin is a plain control or status signal with no valid/ready back-pressure. A service strobe that arrives while no request is pending is simply dropped.

Top module: `i2c_txflag_ctrl`

## Requirements
- R1: With acknowledge checking off (`ack_chk_en`=0), a `byte_done` pulse sets the empty, interrupt and request flags on the next clock edge, whatever the value on `ack_in`.
- R2: With acknowledge checking on and `ack_in`=0 during `byte_done`, all three flags are set on the next clock edge.
- R3: With acknowledge checking on and `ack_in`=1 during `byte_done`, only the interrupt flag is set. The empty and request flags keep their previous values.
- R4: `dma_req` is high only while the request flag is set and `bytes_left` is nonzero. The interrupt flag alone never raises it.
- R5: A `dma_wr` strobe taken while `dma_req` is high clears all three flags and decrements `bytes_left` by one on the next edge. A `dma_wr` strobe while `dma_req` is low changes nothing.
- R6: Once `bytes_left` is 0, the next byte end makes no request, and the interrupt flag stays set until the CPU clears it.
- R7: `irq` is a register that loads (interrupt flag AND `irq_en` AND NOT `dma_req`), so it follows the flag one cycle later, and it stays low while a request is pending.
- R8: A CPU write (`cpu_clr_wr`=1) clears each flag whose bit in `cpu_clr_val` is 0 and leaves the flags whose bit is 1 alone. The bit order is [0] empty, [1] interrupt, [2] request. A set from `byte_done` in the same cycle wins over any clear.
- R9: `ack_in` has no effect on any flag unless `byte_done` is high in that cycle.
- R10: After reset, all flags, `dma_req`, `irq` and `bytes_left` are 0.
- R11: `cnt_load` loads `cnt_load_val` into `bytes_left` on the next edge. It wins over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_done | input | 1 | One-cycle pulse at the end of a transmitted byte |
| ack_in | input | 1 | Acknowledge bit sampled on the ninth clock; used only while byte_done is high |
| ack_chk_en | input | 1 | Acknowledge checking enable |
| dma_wr | input | 1 | Service strobe from the transfer controller (next byte written) |
| cpu_clr_wr | input | 1 | CPU flag write strobe |
| cpu_clr_val | input | 3 | CPU write data; a 0 bit clears the flag ([0] empty, [1] int, [2] req) |
| irq_en | input | 1 | CPU interrupt enable |
| cnt_load | input | 1 | Load strobe for the byte counter |
| cnt_load_val | input | CNT_W | Byte count to load |
| flag_empty | output | 1 | Data-register-empty flag |
| flag_int | output | 1 | Interrupt flag |
| flag_req | output | 1 | Transfer-request flag |
| dma_req | output | 1 | Request to the transfer controller |
| irq | output | 1 | Registered CPU interrupt |
| bytes_left | output | CNT_W | Remaining bytes for the transfer controller |

## Verification
The bench walks through all four combinations of checking enable and acknowledge bit. A design that ignored the checking enable would leave the request up after a NACK and would hide the error from the CPU. The bench then runs a three-byte transfer through the counter and requires `irq` to stay low after every serviced byte and then rise on the byte after the last one. A counter off by one, or an interrupt that leaks for a single cycle before service, shows up here. It also collides a byte end with a CPU clear, collides a counter load with a service strobe, and sends a service strobe with no request pending. A wrong priority in any of these cases leaves the wrong flag or count on the outputs.

// File: rtl/i2c_txflag_pkg.sv
package i2c_txflag_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FL_EMPTY  = 0;
  localparam int unsigned FL_INT    = 1;
  localparam int unsigned FL_REQ    = 2;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  function automatic flag_vec_t all_flags();
    return {NUM_FLAGS{1'b1}};
  endfunction
endpackage

// File: rtl/tf_event_decode.sv
module tf_event_decode
  import i2c_txflag_pkg::*;
(
  input  logic      byte_done,
  input  logic      ack_in,
  input  logic      ack_chk_en,
  output flag_vec_t set_vec
);
  logic acked_ok;

  always_comb begin
    acked_ok = !ack_chk_en || !ack_in;
    set_vec = '0;
    set_vec[FL_INT]   = byte_done;
    set_vec[FL_EMPTY] = byte_done && acked_ok;
    set_vec[FL_REQ]   = byte_done && acked_ok;
  end
endmodule

// File: rtl/tf_flag_bit.sv
module tf_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/tf_byte_counter.sv
module tf_byte_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             nonzero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                 count <= '0;
    else if (load)              count <= load_val;
    else if (dec && nonzero)    count <= count - ONE;
  end

  assign nonzero = |count;
endmodule

// File: rtl/tf_irq_reg.sv
module tf_irq_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic int_flag,
  input  logic irq_en,
  input  logic pending_req,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= int_flag && irq_en && !pending_req;
  end
endmodule

// File: rtl/i2c_txflag_ctrl.sv
module i2c_txflag_ctrl
  import i2c_txflag_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_done,
  input  logic             ack_in,
  input  logic             ack_chk_en,
  input  logic             dma_wr,
  input  logic             cpu_clr_wr,
  input  logic [2:0]       cpu_clr_val,
  input  logic             irq_en,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  output logic             flag_empty,
  output logic             flag_int,
  output logic             flag_req,
  output logic             dma_req,
  output logic             irq,
  output logic [CNT_W-1:0] bytes_left
);
  flag_vec_t set_vec;
  flag_vec_t clr_vec;
  flag_vec_t flags_q;
  logic      cnt_nz;
  logic      dma_take;

  tf_event_decode u_decode (
    .byte_done  (byte_done),
    .ack_in     (ack_in),
    .ack_chk_en (ack_chk_en),
    .set_vec    (set_vec)
  );

  // service is accepted only against a live request
  assign dma_take = dma_wr && dma_req;

  always_comb begin
    clr_vec = '0;
    if (cpu_clr_wr) clr_vec = clr_vec | ~flag_vec_t'(cpu_clr_val);
    if (dma_take)   clr_vec = clr_vec | all_flags();
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    tf_flag_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q     (flags_q[i])
    );
  end

  tf_byte_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (dma_take),
    .count    (bytes_left),
    .nonzero  (cnt_nz)
  );

  assign flag_empty = flags_q[FL_EMPTY];
  assign flag_int   = flags_q[FL_INT];
  assign flag_req   = flags_q[FL_REQ];
  assign dma_req    = flags_q[FL_REQ] && cnt_nz;

  tf_irq_reg u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_flag    (flags_q[FL_INT]),
    .irq_en      (irq_en),
    .pending_req (dma_req),
    .irq         (irq)
  );
endmodule

// File: rtl/i2c_txflag_ctrl_chk.sv
module i2c_txflag_ctrl_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_done,
  input logic             ack_in,
  input logic             ack_chk_en,
  input logic             dma_wr,
  input logic             cnt_load,
  input logic             irq_en,
  input logic             flag_empty,
  input logic             flag_int,
  input logic             flag_req,
  input logic             dma_req,
  input logic             irq,
  input logic [CNT_W-1:0] bytes_left
);
  a_r1_nochk_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !ack_chk_en |=> flag_empty && flag_int && flag_req);

  a_r2_ack_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && ack_chk_en && !ack_in |=> flag_empty && flag_int && flag_req);

  a_r3_nack_only_int: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && ack_chk_en && ack_in && !flag_req |=> flag_int && !flag_req);

  a_r4_no_req_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_req || bytes_left == '0 |-> !dma_req);

  a_r5_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr && dma_req && !byte_done && !cnt_load |=>
      !flag_empty && !flag_int && !flag_req &&
      (bytes_left + CNT_W'(1)) == $past(bytes_left));

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    flag_int && irq_en && !dma_req |=> irq);

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_int || !irq_en || dma_req |=> !irq);
endmodule

bind i2c_txflag_ctrl i2c_txflag_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_done  (byte_done),
  .ack_in     (ack_in),
  .ack_chk_en (ack_chk_en),
  .dma_wr     (dma_wr),
  .cnt_load   (cnt_load),
  .irq_en     (irq_en),
  .flag_empty (flag_empty),
  .flag_int   (flag_int),
  .flag_req   (flag_req),
  .dma_req    (dma_req),
  .irq        (irq),
  .bytes_left (bytes_left)
);

// File: tb/i2c_txflag_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_txflag_ctrl_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_done = 1'b0, ack_in = 1'b0, ack_chk_en = 1'b0, dma_wr = 1'b0;
  logic cpu_clr_wr = 1'b0, irq_en = 1'b0, cnt_load = 1'b0;
  logic [2:0] cpu_clr_val = 3'b111;
  logic [CNT_W-1:0] cnt_load_val = '0;
  logic flag_empty, flag_int, flag_req, dma_req, irq;
  logic [CNT_W-1:0] bytes_left;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  i2c_txflag_ctrl #(.CNT_W(CNT_W)) u_i2c_txflag_ctrl (
    .clk, .rst_n, .byte_done, .ack_in, .ack_chk_en, .dma_wr, .cpu_clr_wr,
    .cpu_clr_val, .irq_en, .cnt_load, .cnt_load_val, .flag_empty, .flag_int,
    .flag_req, .dma_req, .irq, .bytes_left
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // flags packed as {req,int,empty}
  function automatic int flags();
    return {flag_req, flag_int, flag_empty};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; byte_done = 0; dma_wr = 0; cpu_clr_wr = 0; cnt_load = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic byte_end(input logic chk, input logic ack);
    @(negedge clk);
    ack_chk_en = chk; ack_in = ack; byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0; ack_in = ~ack;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 flags", flags(), 0);
    check("R10 dma_req", dma_req, 0);
    check("R10 irq", irq, 0);
    check("R10 bytes_left", bytes_left, 0);
  endtask

  task automatic t_ack_matrix();
    do_reset(); irq_en = 1'b1;
    byte_end(1'b0, 1'b0);
    check("R1 nochk ack0", flags(), 7);
    do_reset();
    byte_end(1'b0, 1'b1);
    check("R1 nochk ack1", flags(), 7);
    do_reset();
    byte_end(1'b1, 1'b0);
    check("R2 chk ack0", flags(), 7);
    do_reset();
    cnt_load_val = 8'd4; cnt_load = 1'b1;
    @(negedge clk); cnt_load = 1'b0;
    byte_end(1'b1, 1'b1);
    check("R3 chk nack flags", flags(), 2);
    check("R4 int alone no request", dma_req, 0);
    @(negedge clk);
    check("R7 irq after nack", irq, 1);
  endtask

  task automatic t_irq_mask();
    do_reset(); irq_en = 1'b0;
    byte_end(1'b1, 1'b1);
    @(negedge clk);
    check("R7 irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check("R7 irq unmasked", irq, 1);
  endtask

  task automatic t_cpu_clear();
    do_reset(); irq_en = 1'b0;
    byte_end(1'b0, 1'b0);
    @(negedge clk);
    cpu_clr_wr = 1'b1; cpu_clr_val = 3'b101;
    @(negedge clk);
    cpu_clr_wr = 1'b0; cpu_clr_val = 3'b111;
    check("R8 clear int only", flags(), 5);
    @(negedge clk);
    cpu_clr_wr = 1'b1; cpu_clr_val = 3'b000;
    byte_done = 1'b1; ack_chk_en = 1'b1; ack_in = 1'b1;
    @(negedge clk);
    cpu_clr_wr = 1'b0; cpu_clr_val = 3'b111; byte_done = 1'b0;
    check("R8 set wins int, others cleared", flags(), 2);
  endtask

  task automatic t_ack_ignored();
    do_reset();
    ack_chk_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ack_in = ~ack_in;
    end
    @(negedge clk);
    check("R9 ack without byte_done", flags(), 0);
  endtask

  task automatic t_dma_run();
    do_reset(); irq_en = 1'b1;
    @(negedge clk);
    dma_wr = 1'b1;
    @(negedge clk);
    dma_wr = 1'b0;
    check("R5 stray service count", bytes_left, 0);
    cnt_load_val = 8'd3; cnt_load = 1'b1;
    @(negedge clk); cnt_load = 1'b0;
    check("R11 load", bytes_left, 3);
    for (int b = 0; b < 3; b++) begin
      byte_end(1'b1, 1'b0);
      check("R4 request raised", dma_req, 1);
      dma_wr = 1'b1;
      @(negedge clk);
      dma_wr = 1'b0;
      check("R7 no irq during service", irq, 0);
      check("R5 service clears flags", flags(), 0);
      check("R5 count decrements", bytes_left, 2 - b);
      @(negedge clk);
      check("R7 irq stays low", irq, 0);
    end
    byte_end(1'b1, 1'b0);
    check("R6 no request at zero", dma_req, 0);
    @(negedge clk);
    check("R6 cpu interrupted after last", irq, 1);
    dma_wr = 1'b1;
    @(negedge clk);
    dma_wr = 1'b0;
    check("R5 unrequested service ignored", flags(), 7);
    check("R6 int held", irq, 1);
  endtask

  task automatic t_load_priority();
    do_reset();
    cnt_load_val = 8'd2; cnt_load = 1'b1;
    @(negedge clk); cnt_load = 1'b0;
    byte_end(1'b0, 1'b1);
    cnt_load_val = 8'd5; cnt_load = 1'b1; dma_wr = 1'b1;
    @(negedge clk);
    cnt_load = 1'b0; dma_wr = 1'b0;
    check("R11 load beats decrement", bytes_left, 5);
    check("R5 service with load clears", flags(), 0);
  endtask

  initial begin
    t_reset();
    t_ack_matrix();
    t_irq_mask();
    t_cpu_clear();
    t_ack_ignored();
    t_dma_run();
    t_load_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule